// File: doc/BRIEF.md
# Boundary Scan Register Segment

This block is a parameterised slice of a boundary scan data register. It holds three kinds of cell: observe-only cells that sample a pin, output cells that sample a core output and drive a pin through an update latch, and one control cell that enables or disables a whole group of tri-state drivers. The group is a bidirectional bus, and each bus pin pairs an observe-only cell for the pad input with a tri-state output cell for the driver. Internal cells sit in the chain as placeholders. They shift data but reach no pin.

A test access port controller, outside this block, drives single-cycle capture, shift and update strobes, a test-mode select and an all-drivers-off request. In functional mode the pins follow the core and the scan path works in the background without disturbing them. In test mode the update latches drive the pins. A 1 held in the control cell's latch releases every driver in the bus.

Top module: `bscan_segment`

## Requirements
- R1: On each clock with `shift_en` high and `capture_en` low, every cell takes the value of the cell one index above it, the highest cell takes `tdi`, and `tdo` always shows cell 0. The chain is L = N_IN + N_INT + N_OUT2 + 2*N_BUS + 1 cells long.
- R2: Cell indices, counted from the `tdo` end, are as follows. Input pin k is at k, internal cells come next, and two-state output k is at B2+k with B2 = N_IN+N_INT. Bus pin k uses output cell BB+2k and observe cell BB+2k+1, with BB = B2+N_OUT2. The control cell is last, at index L-1.
- R3: On `capture_en`, each input observe cell loads its `in_pin` bit. These cells never affect any output pin.
- R4: On `capture_en`, each two-state and tri-state output cell loads its core data bit (`core_out2`, `core_bd_out`), and each bus observe cell loads its pad input `bd_pin_in`.
- R5: On `capture_en`, the control cell loads the inverse of `core_bd_oe`.
- R6: On `capture_en`, internal cells load 0. They still pass shifted data along.
- R7: Update latches load their cells only on a clock with `update_en` high. After reset the data latches hold 0 and the control latch holds 1 (drivers off).
- R8: With `test_mode` low, `pin_out2` equals `core_out2`, `bd_pin_out` equals `core_bd_out` and `bd_pin_oe` equals `core_bd_oe` on every bit (unless R10 applies), whatever the latches hold.
- R9: With `test_mode` high, `pin_out2` and `bd_pin_out` come from the data latches. A control latch of 0 enables all `bd_pin_oe` bits and a 1 clears them all.
- R10: With `all_hiz` high, every `bd_pin_oe` bit is 0 in either mode, whatever the control latch holds. Two-state outputs are unaffected.
- R11: When `capture_en` and `shift_en` are both high, capture wins. After reset every cell holds 0, so `tdo` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| test_mode | input | 1 | 1: pins driven from update latches |
| all_hiz | input | 1 | Force every bus driver off |
| tdi | input | 1 | Serial data in (highest cell) |
| tdo | output | 1 | Serial data out (cell 0) |
| in_pin | input | N_IN | Input-only pin values |
| core_out2 | input | N_OUT2 | Core data for two-state outputs |
| pin_out2 | output | N_OUT2 | Two-state output pins |
| core_bd_out | input | N_BUS | Core data for bus drivers |
| core_bd_oe | input | 1 | Core enable for the bus group |
| bd_pin_in | input | N_BUS | Pad input values of the bus |
| bd_pin_out | output | N_BUS | Bus driver data |
| bd_pin_oe | output | N_BUS | Bus driver enables (0 = high-impedance) |

## Verification
A wrong capture source or a wrong cell position shows up only on `tdo`, at the exact shift count equal to that cell's index after a capture. The bench therefore compares every bit of a full unload against a vector built from R2, and then shifts a known pattern through twice the chain length. A control latch stuck at the wrong value, or inverted, shows on all bus enables in the first cycle after an update in test mode. A latch that loads without an update strobe shows as pins moving while a new pattern is shifted in, before the update arrives.

// File: rtl/bscan_seg_pkg.sv
// Package: cell kinds and index layout shared by the boundary scan segment.
// Assumes every group count is at least 1.
package bscan_seg_pkg;

    typedef enum logic [2:0] {
        CK_IN   = 3'd0,   // observe-only, input pin
        CK_INT  = 3'd1,   // placeholder, no pin
        CK_OUT2 = 3'd2,   // two-state output
        CK_OUT3 = 3'd3,   // tri-state output of a bus pin
        CK_BOBS = 3'd4,   // observe-only, bus pad input
        CK_CTL  = 3'd5    // group control cell
    } cell_kind_e;

    // Kind of the cell at index idx (0 = tdo end).
    function automatic cell_kind_e cell_kind(input int idx, input int ni, input int nx,
                                             input int no2, input int nb);
        int b2;
        int bb;
        b2 = ni + nx;
        bb = b2 + no2;
        if (idx < ni)                 return CK_IN;
        else if (idx < b2)            return CK_INT;
        else if (idx < bb)            return CK_OUT2;
        else if (idx < bb + 2 * nb)   return ((idx - bb) % 2 == 0) ? CK_OUT3 : CK_BOBS;
        else                          return CK_CTL;
    endfunction

endpackage

// File: rtl/bsr_chain.sv
// Capture/shift stage of every cell. Knows the layout, builds the capture
// vector per cell kind and taps the bits that feed the update latches.
// Assumes the strobes are single-cycle and qualified by the TAP.
module bsr_chain #(
    parameter int N_IN   = 3,
    parameter int N_INT  = 2,
    parameter int N_OUT2 = 2,
    parameter int N_BUS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [N_IN-1:0]   in_pin,
    input  logic [N_OUT2-1:0] core_out2,
    input  logic [N_BUS-1:0]  core_bd_out,
    input  logic              core_bd_oe,
    input  logic [N_BUS-1:0]  bd_pin_in,
    output logic              tdo,
    output logic [N_OUT2-1:0] tap_out2,
    output logic [N_BUS-1:0]  tap_bd,
    output logic              tap_ctl
);
    import bscan_seg_pkg::*;

    localparam int B2  = N_IN + N_INT;
    localparam int BB  = B2 + N_OUT2;
    localparam int LEN = BB + 2 * N_BUS + 1;

    logic [LEN-1:0] cells;
    logic [LEN-1:0] cap_vec;

    // Per-cell capture source, selected by the cell's kind.
    for (genvar i = 0; i < LEN; i++) begin : g_cap
        localparam cell_kind_e KIND = cell_kind(i, N_IN, N_INT, N_OUT2, N_BUS);
        if (KIND == CK_IN) begin : g_in
            assign cap_vec[i] = in_pin[i];
        end else if (KIND == CK_INT) begin : g_int
            assign cap_vec[i] = 1'b0;
        end else if (KIND == CK_OUT2) begin : g_o2
            assign cap_vec[i] = core_out2[i - B2];
        end else if (KIND == CK_OUT3) begin : g_o3
            assign cap_vec[i] = core_bd_out[(i - BB) / 2];
        end else if (KIND == CK_BOBS) begin : g_bo
            assign cap_vec[i] = bd_pin_in[(i - BB - 1) / 2];
        end else begin : g_ctl
            assign cap_vec[i] = ~core_bd_oe;
        end
    end

    // Capture has priority over shift; shift moves data toward cell 0.
    always_ff @(posedge clk) begin
        if (!rst_n)          cells <= '0;
        else if (capture_en) cells <= cap_vec;
        else if (shift_en)   cells <= {tdi, cells[LEN-1:1]};
    end

    assign tdo     = cells[0];
    assign tap_ctl = cells[LEN-1];
    for (genvar k = 0; k < N_OUT2; k++) begin : g_t2
        assign tap_out2[k] = cells[B2 + k];
    end
    for (genvar k = 0; k < N_BUS; k++) begin : g_tb
        assign tap_bd[k] = cells[BB + 2 * k];
    end

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !capture_en |=> tdo == $past(cells[1]));
    // R11
    cap_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en && shift_en |=> tdo == $past(cap_vec[0]));

endmodule

// File: rtl/bsr_update.sv
// Update latch bank: loads from the scan stage on the update strobe only.
// Reset value is a parameter so control latches can reset to "disabled".
module bsr_update #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         update_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold unless the update strobe is present.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= RST_VAL;
        else if (update_en) q <= d;
    end
endmodule

// File: rtl/bsr_pin_ctl.sv
// Pin selection: core signals in functional mode, update latches in test
// mode; the all-off request overrides every bus enable in both modes.
module bsr_pin_ctl #(
    parameter int N_OUT2 = 2,
    parameter int N_BUS  = 8
) (
    input  logic              test_mode,
    input  logic              all_hiz,
    input  logic [N_OUT2-1:0] core_out2,
    input  logic [N_OUT2-1:0] upd_out2,
    input  logic [N_BUS-1:0]  core_bd_out,
    input  logic              core_bd_oe,
    input  logic [N_BUS-1:0]  upd_bd,
    input  logic              upd_ctl,
    output logic [N_OUT2-1:0] pin_out2,
    output logic [N_BUS-1:0]  bd_pin_out,
    output logic [N_BUS-1:0]  bd_pin_oe
);
    logic grp_en;

    // One enable for the whole bus group.
    always_comb begin
        grp_en = test_mode ? ~upd_ctl : core_bd_oe;
        if (all_hiz) grp_en = 1'b0;
    end

    for (genvar k = 0; k < N_OUT2; k++) begin : g_o2
        assign pin_out2[k] = test_mode ? upd_out2[k] : core_out2[k];
    end
    for (genvar k = 0; k < N_BUS; k++) begin : g_bd
        assign bd_pin_out[k] = test_mode ? upd_bd[k] : core_bd_out[k];
        assign bd_pin_oe[k]  = grp_en;
    end
endmodule

// File: rtl/bscan_segment.sv
// Top of the boundary scan segment: scan stage, data and control update
// latches, pin selection. Strobes come from an external TAP controller.
module bscan_segment #(
    parameter int N_IN   = 3,
    parameter int N_INT  = 2,
    parameter int N_OUT2 = 2,
    parameter int N_BUS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              test_mode,
    input  logic              all_hiz,
    input  logic              tdi,
    output logic              tdo,
    input  logic [N_IN-1:0]   in_pin,
    input  logic [N_OUT2-1:0] core_out2,
    output logic [N_OUT2-1:0] pin_out2,
    input  logic [N_BUS-1:0]  core_bd_out,
    input  logic              core_bd_oe,
    input  logic [N_BUS-1:0]  bd_pin_in,
    output logic [N_BUS-1:0]  bd_pin_out,
    output logic [N_BUS-1:0]  bd_pin_oe
);
    localparam int DW = N_OUT2 + N_BUS;

    logic [N_OUT2-1:0] tap_out2;
    logic [N_BUS-1:0]  tap_bd;
    logic              tap_ctl;
    logic [DW-1:0]     dat_q;
    logic [0:0]        ctl_q;

    bsr_chain #(.N_IN(N_IN), .N_INT(N_INT), .N_OUT2(N_OUT2), .N_BUS(N_BUS)) u_chain (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .tdi(tdi), .in_pin(in_pin), .core_out2(core_out2), .core_bd_out(core_bd_out),
        .core_bd_oe(core_bd_oe), .bd_pin_in(bd_pin_in), .tdo(tdo),
        .tap_out2(tap_out2), .tap_bd(tap_bd), .tap_ctl(tap_ctl)
    );

    bsr_update #(.W(DW), .RST_VAL('0)) u_dat (
        .clk(clk), .rst_n(rst_n), .update_en(update_en),
        .d({tap_bd, tap_out2}), .q(dat_q)
    );

    bsr_update #(.W(1), .RST_VAL(1'b1)) u_ctl (
        .clk(clk), .rst_n(rst_n), .update_en(update_en),
        .d(tap_ctl), .q(ctl_q)
    );

    bsr_pin_ctl #(.N_OUT2(N_OUT2), .N_BUS(N_BUS)) u_pins (
        .test_mode(test_mode), .all_hiz(all_hiz),
        .core_out2(core_out2), .upd_out2(dat_q[N_OUT2-1:0]),
        .core_bd_out(core_bd_out), .core_bd_oe(core_bd_oe),
        .upd_bd(dat_q[DW-1:N_OUT2]), .upd_ctl(ctl_q[0]),
        .pin_out2(pin_out2), .bd_pin_out(bd_pin_out), .bd_pin_oe(bd_pin_oe)
    );

    // R3
    cap_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> tdo == $past(in_pin[0]));
    // R10
    hiz_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_hiz |-> bd_pin_oe == '0);
    // R8
    func_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> pin_out2 == core_out2 && bd_pin_out == core_bd_out);
    // R9
    ctl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode && !all_hiz && $past(rst_n) && $past(update_en)
        |-> bd_pin_oe == {N_BUS{~$past(tap_ctl)}});
    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode && $past(test_mode) && $past(rst_n) && !$past(update_en)
        |-> $stable(pin_out2) && $stable(bd_pin_out));

endmodule

// File: tb/tb_bscan_segment.sv
module tb_bscan_segment;
    localparam int NI  = 3;
    localparam int NX  = 2;
    localparam int NO2 = 2;
    localparam int NB  = 8;
    localparam int B2  = NI + NX;
    localparam int BB  = B2 + NO2;
    localparam int L   = BB + 2 * NB + 1;
    localparam int CTL = L - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_en = 0, shift_en = 0, update_en = 0, test_mode = 0, all_hiz = 0, tdi = 0;
    logic [NI-1:0]  in_pin = '0;
    logic [NO2-1:0] core_out2 = '0;
    logic [NB-1:0]  core_bd_out = '0;
    logic           core_bd_oe = 1'b0;
    logic [NB-1:0]  bd_pin_in = '0;
    logic           tdo;
    logic [NO2-1:0] pin_out2;
    logic [NB-1:0]  bd_pin_out, bd_pin_oe;

    int total = 0;
    int bad = 0;
    logic  exp_q[$];
    string tag_q[$];
    int    idx_q[$];

    always #2 clk = ~clk;

    bscan_segment #(.N_IN(NI), .N_INT(NX), .N_OUT2(NO2), .N_BUS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .test_mode(test_mode), .all_hiz(all_hiz), .tdi(tdi),
        .tdo(tdo), .in_pin(in_pin), .core_out2(core_out2), .pin_out2(pin_out2),
        .core_bd_out(core_bd_out), .core_bd_oe(core_bd_oe), .bd_pin_in(bd_pin_in),
        .bd_pin_out(bd_pin_out), .bd_pin_oe(bd_pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares tdo against the scoreboard while shifting.
    always @(negedge clk) begin
        if (shift_en && exp_q.size() != 0) begin
            logic  e;
            string t;
            int    ix;
            e  = exp_q.pop_front();
            t  = tag_q.pop_front();
            ix = idx_q.pop_front();
            total++;
            if (tdo !== e) begin
                bad++;
                $display("FAIL %s cell %0d actual=%0b expected=%0b", t, ix, tdo, e);
            end
        end
    end

    function automatic string tag_of(input int i);
        if (i >= L)       return "R1";
        if (i < NI)       return "R2 R3";
        if (i < B2)       return "R2 R6";
        if (i < BB)       return "R2 R4";
        if (i < CTL)      return "R2 R4";
        return "R2 R5";
    endfunction

    // Expected capture vector built from the layout in R2.
    function automatic logic [L-1:0] cap_model();
        logic [L-1:0] v;
        v = '0;
        for (int k = 0; k < NI; k++)  v[k] = in_pin[k];
        for (int k = 0; k < NO2; k++) v[B2 + k] = core_out2[k];
        for (int k = 0; k < NB; k++) begin
            v[BB + 2 * k]     = core_bd_out[k];
            v[BB + 2 * k + 1] = bd_pin_in[k];
        end
        v[CTL] = ~core_bd_oe;
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_capture();
        capture_en = 1'b1;
        step();
        capture_en = 1'b0;
    endtask

    task automatic pulse_update();
        update_en = 1'b1;
        step();
        update_en = 1'b0;
    endtask

    // Driver: shifts d in (bit 0 first); optionally queues exp as the tdo stream.
    task automatic shift_bits(input logic [L-1:0] d, input bit push,
                              input logic [L-1:0] exp, input int base);
        for (int i = 0; i < L; i++) begin
            tdi = d[i];
            shift_en = 1'b1;
            if (push) begin
                exp_q.push_back(exp[i]);
                tag_q.push_back(tag_of(base + i));
                idx_q.push_back(i);
            end
            step();
        end
        shift_en = 1'b0;
        tdi = 1'b0;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [L-1:0] p;
        logic [L-1:0] cv;
        in_pin = 3'b101; core_out2 = 2'b10; core_bd_out = 8'hA5; core_bd_oe = 1'b1;
        bd_pin_in = 8'h3C;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        @(negedge clk);
        check("R11 reset tdo", {31'd0, tdo}, 32'd0);
        check("R8 out2 follows core", {30'd0, pin_out2}, {30'd0, core_out2});
        check("R8 bus follows core", {24'd0, bd_pin_out}, {24'd0, core_bd_out});
        check("R8 oe follows core", {24'd0, bd_pin_oe}, 32'h0FF);

        // Reset values of the latches seen in test mode.
        test_mode = 1'b1;
        @(negedge clk);
        check("R7 reset data latch out2", {30'd0, pin_out2}, 32'd0);
        check("R7 reset data latch bus", {24'd0, bd_pin_out}, 32'd0);
        check("R7 reset ctl latch off", {24'd0, bd_pin_oe}, 32'd0);

        // Capture pattern A and unload.
        step();
        cv = cap_model();
        pulse_capture();
        shift_bits('0, 1'b1, cv, 0);

        // Load a pattern with control 0; pins must not move before update.
        p = '0;
        p[B2 +: NO2] = 2'b01;
        for (int k = 0; k < NB; k++) p[BB + 2 * k] = k[0];
        p[CTL] = 1'b0;
        shift_bits(p, 1'b0, '0, 0);
        @(negedge clk);
        check("R7 no update yet out2", {30'd0, pin_out2}, 32'd0);
        check("R7 no update yet oe", {24'd0, bd_pin_oe}, 32'd0);
        step();
        pulse_update();
        @(negedge clk);
        check("R9 out2 from latch", {30'd0, pin_out2}, 32'd1);
        check("R9 bus from latch", {24'd0, bd_pin_out}, 32'hAA);
        check("R9 ctl 0 enables all", {24'd0, bd_pin_oe}, 32'hFF);
        all_hiz = 1'b1;
        @(negedge clk);
        check("R10 all off in test mode", {24'd0, bd_pin_oe}, 32'd0);
        check("R10 out2 unaffected", {30'd0, pin_out2}, 32'd1);
        all_hiz = 1'b0;

        // Control 1 disables the whole group.
        step();
        p[CTL] = 1'b1;
        for (int k = 0; k < NB; k++) p[BB + 2 * k] = (k < 4);
        p[B2 +: NO2] = 2'b10;
        shift_bits(p, 1'b0, '0, 0);
        pulse_update();
        @(negedge clk);
        check("R9 ctl 1 disables all", {24'd0, bd_pin_oe}, 32'd0);
        check("R9 bus data latched", {24'd0, bd_pin_out}, 32'h0F);
        check("R9 out2 latched", {30'd0, pin_out2}, 32'd2);

        // Functional mode ignores the latches.
        test_mode = 1'b0;
        core_out2 = 2'b11; core_bd_out = 8'h5E; core_bd_oe = 1'b1;
        @(negedge clk);
        check("R8 out2 core", {30'd0, pin_out2}, 32'd3);
        check("R8 bus core", {24'd0, bd_pin_out}, 32'h5E);
        check("R8 oe core", {24'd0, bd_pin_oe}, 32'hFF);
        all_hiz = 1'b1;
        @(negedge clk);
        check("R10 all off in functional mode", {24'd0, bd_pin_oe}, 32'd0);
        all_hiz = 1'b0;
        core_bd_oe = 1'b0;
        @(negedge clk);
        check("R8 oe core low", {24'd0, bd_pin_oe}, 32'd0);

        // Capture pattern B, shift a known word in, then shift it back out.
        step();
        in_pin = 3'b010; core_bd_out = 8'hC3; bd_pin_in = 8'h96; core_out2 = 2'b01;
        cv = cap_model();
        pulse_capture();
        p = 24'h9D3A61;
        shift_bits(p, 1'b1, cv, 0);
        shift_bits('0, 1'b1, p, L);

        // Capture wins over shift in the same cycle.
        in_pin = 3'b001;
        capture_en = 1'b1;
        shift_en = 1'b1;
        tdi = 1'b0;
        step();
        capture_en = 1'b0;
        shift_en = 1'b0;
        @(negedge clk);
        check("R11 capture over shift", {31'd0, tdo}, 32'd1);
        step();
        check("R1 R2 scoreboard drained", exp_q.size(), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule